// File: doc/BRIEF.md
# Time-Multiplexed FIR Filter with Run-Time Coefficient Reload

This block is a direct-form FIR filter that spends several system clocks on each input sample. A small set of multipliers is shared across the taps. A phase counter steps through one sample period, picks which stored taps feed each multiplier, and adds their products into an accumulator. With the default 11 taps and 7 phases, two multipliers do the work. The first covers taps 0 to 6. The second covers taps 7 to 10 and is idle in the last three phases. At the end of the period the sum is rounded and saturated to a 16-bit Q15 sample, then placed in a result register.

Samples enter and leave on valid/ready streams. A transfer takes place on a rising edge where valid, ready and `clk_en` are all high. A source must hold `in_valid` and `in_data` until the transfer. `out_valid` and `out_data` stay unchanged while `out_ready` is low. When the internal stages fill, `in_ready` drops. An optional input register and an optional output register each add one cycle of latency and one stage of buffering.

Coefficients are reloaded at run time through a plain write port. Each write stores one value in a shadow bank. Pulsing `coef_done` arms a swap. The shadow bank is copied into the active bank when the next sample starts its computation. A sample that is already in the datapath, or that starts before the done pulse, finishes with the old set. Reset clears the taps and both coefficient banks to zero. Every register resets asynchronously and advances only while `clk_en` is high.

Top module: `sfir_prog`

## Requirements
- R1: While `rst` is high and right after it, `out_valid` is 0 and `in_ready` is 1. The taps and both coefficient banks are zero, so samples processed before any coefficient swap produce 0.
- R2: Each output equals sum over k of c[k]·x[n−k], where c[0] weights the newest sample. Coefficients and samples are signed Q15. The sum is rounded by adding 2^14 and shifting right arithmetically by 15. Outputs appear in input order.
- R3: With input always valid and output always ready, the filter accepts one sample every 7 clocks, so consecutive outputs are exactly 7 clocks apart.
- R4: With both optional registers present and the filter idle, `out_valid` rises on the 9th rising edge after the edge that accepts the input sample.
- R5: A write with `coef_we` high and `coef_addr` below 11 stores `coef_din` in shadow slot `coef_addr`. Writes to addresses 11 to 15 change nothing.
- R6: A sample whose computation starts before the `coef_done` pulse uses the old coefficient set, even if shadow writes happen while it is being processed.
- R7: Shadow writes take effect only after `coef_done`. The first sample to start after the pulse, and every later one, uses the new set.
- R8: While `out_ready` is low, `out_valid` and `out_data` hold their values. Once all stages are full, `in_ready` is 0. No result is lost or reordered.
- R9: While `clk_en` is low, no state changes and no transfer takes place. `out_valid` and `out_data` hold their values.
- R10: Results above 32767 are saturated to 32767, and results below −32768 are saturated to −32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several cycles per sample |
| rst | input | 1 | Asynchronous active-high reset |
| clk_en | input | 1 | Clock enable for all registers and transfers |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Filter can take an input sample |
| in_data | input | 16 | Signed Q15 input sample |
| out_valid | output | 1 | Output sample is valid |
| out_ready | input | 1 | Sink can take the output sample |
| out_data | output | 16 | Signed Q15 filtered sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_done | input | 1 | One-cycle pulse that arms the coefficient swap |
| coef_addr | input | 4 | Shadow slot to write |
| coef_din | input | 16 | Signed Q15 coefficient value |

## Verification
The filter is driven with several coefficient and sample patterns. All-zero coefficients confirm that reset leaves no residue in the datapath. A single half-weight tap with small inputs checks the rounding step. A mixed-sign ramp of coefficients with alternating samples catches a multiplier that is fed the wrong tap in some phase. Full-scale inputs of both signs check saturation. Coefficient reloads are tested at three points: during a running sample, with writes left unconfirmed, and with an out-of-range address. This separates the shadow set from the active set and finds the exact sample at which the swap happens. Back-to-back bursts, a stalled sink and a frozen clock enable check throughput, hold behaviour and ordering.

// File: rtl/sfir_pkg.sv
package sfir_pkg;
  localparam int DATA_W_DEF = 16;
  localparam int COEF_W_DEF = 16;
  localparam int FRAC_W_DEF = 15;
  localparam int NTAPS_DEF  = 11;
  localparam int PHASES_DEF = 7;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/sfir_coef_bank.sv
module sfir_coef_bank #(
  parameter int NTAPS  = 11,
  parameter int COEF_W = 16,
  parameter int AW     = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ce,
  input  logic                     wr_en,
  input  logic                     wr_done,
  input  logic [AW-1:0]            wr_addr,
  input  logic signed [COEF_W-1:0] wr_data,
  input  logic                     sample_start,
  output logic signed [COEF_W-1:0] act_coef [NTAPS]
);
  logic signed [COEF_W-1:0] shadow [NTAPS];
  logic armed;
  logic swap;

  // A done pulse in the same cycle as a sample start applies to that sample.
  assign swap = sample_start && (armed || wr_done);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) armed <= 1'b0;
    else if (ce) armed <= (armed || wr_done) && !swap;
  end

  for (genvar i = 0; i < NTAPS; i++) begin : g_slot
    always_ff @(posedge clk or posedge rst) begin
      if (rst) shadow[i] <= '0;
      else if (ce && wr_en && (wr_addr == AW'(i))) shadow[i] <= wr_data;
    end

    always_ff @(posedge clk or posedge rst) begin
      if (rst) act_coef[i] <= '0;
      else if (ce && swap) act_coef[i] <= shadow[i];
    end

    // R7: the active set moves only at a swap
    a_r7_active_hold: assert property (@(posedge clk) disable iff (rst)
      !(ce && swap) |=> $stable(act_coef[i]));
  end
endmodule

// File: rtl/sfir_tap_line.sv
module sfir_tap_line #(
  parameter int NTAPS  = 11,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ce,
  input  logic                     shift,
  input  logic signed [DATA_W-1:0] din,
  output logic signed [DATA_W-1:0] taps [NTAPS]
);
  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    always_ff @(posedge clk or posedge rst) begin
      if (rst) taps[i] <= '0;
      else if (ce && shift) begin
        if (i == 0) taps[i] <= din;
        else        taps[i] <= taps[(i == 0) ? 0 : i-1];
      end
    end
  end
endmodule

// File: rtl/sfir_mac.sv
module sfir_mac #(
  parameter int NTAPS  = 11,
  parameter int PHASES = 7,
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 15,
  parameter int NMULT  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ce,
  input  logic                     start,
  input  logic signed [DATA_W-1:0] taps [NTAPS],
  input  logic signed [COEF_W-1:0] coefs [NTAPS],
  input  logic                     res_pop,
  output logic                     ready,
  output logic                     res_v,
  output logic signed [DATA_W-1:0] res_q
);
  localparam int PW    = DATA_W + COEF_W;
  localparam int ACC_W = PW + $clog2(NTAPS) + 1;
  localparam int PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(2 ** (FRAC_W - 1));
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'(2 ** (DATA_W - 1) - 1);
  localparam logic signed [ACC_W-1:0] MINV = ACC_W'(-(2 ** (DATA_W - 1)));

  logic                    busy;
  logic [PH_W-1:0]         phase;
  logic signed [ACC_W-1:0] acc, sum, acc_next;
  logic signed [PW-1:0]    prod [NMULT];
  logic                    room, advance, finish;

  function automatic logic signed [DATA_W-1:0] round_sat(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] t;
    t = (a + HALF) >>> FRAC_W;
    if (t > MAXV)      return MAXV[DATA_W-1:0];
    else if (t < MINV) return MINV[DATA_W-1:0];
    else               return t[DATA_W-1:0];
  endfunction

  // multiplier m serves taps m*PHASES .. m*PHASES+PHASES-1
  for (genvar m = 0; m < NMULT; m++) begin : g_mul
    always_comb begin
      int idx;
      idx = m * PHASES + int'(phase);
      if (idx < NTAPS) prod[m] = taps[idx] * coefs[idx];
      else             prod[m] = '0;
    end
  end

  always_comb begin
    sum = '0;
    for (int m = 0; m < NMULT; m++) sum += ACC_W'(prod[m]);
  end

  assign acc_next = ((phase == '0) ? '0 : acc) + sum;
  assign room     = !res_v || res_pop;
  assign advance  = busy && ((phase != LAST) || room);
  assign finish   = busy && (phase == LAST) && room;
  assign ready    = !busy || finish;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      busy  <= 1'b0;
      phase <= '0;
      acc   <= '0;
    end else if (ce) begin
      if (advance) acc <= acc_next;
      if (start) begin
        busy  <= 1'b1;
        phase <= '0;
      end else if (finish) begin
        busy  <= 1'b0;
      end else if (advance) begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      res_v <= 1'b0;
      res_q <= '0;
    end else if (ce) begin
      if (finish) begin
        res_v <= 1'b1;
        res_q <= round_sat(acc_next);
      end else if (res_pop) begin
        res_v <= 1'b0;
      end
    end
  end

  // R3: phase stays inside one sample period
  a_r3_phase_range: assert property (@(posedge clk) disable iff (rst)
    busy |-> (int'(phase) < PHASES));

  // R8: an unconsumed result is never overwritten
  a_r8_result_kept: assert property (@(posedge clk) disable iff (rst)
    (res_v && !res_pop) |=> (res_v && $stable(res_q)));
endmodule

// File: rtl/sfir_prog.sv
module sfir_prog #(
  parameter int NTAPS   = sfir_pkg::NTAPS_DEF,
  parameter int PHASES  = sfir_pkg::PHASES_DEF,
  parameter int DATA_W  = sfir_pkg::DATA_W_DEF,
  parameter int COEF_W  = sfir_pkg::COEF_W_DEF,
  parameter int FRAC_W  = sfir_pkg::FRAC_W_DEF,
  parameter bit IN_REG  = 1'b1,
  parameter bit OUT_REG = 1'b1,
  localparam int AW     = (NTAPS > 1) ? $clog2(NTAPS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clk_en,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_data,
  input  logic                     coef_we,
  input  logic                     coef_done,
  input  logic [AW-1:0]            coef_addr,
  input  logic signed [COEF_W-1:0] coef_din
);
  localparam int NMULT = sfir_pkg::ceil_div(NTAPS, PHASES);

  logic                     core_valid, core_ready, core_start;
  logic signed [DATA_W-1:0] core_data;
  logic                     res_v, res_pop;
  logic signed [DATA_W-1:0] res_q;
  logic signed [DATA_W-1:0] taps  [NTAPS];
  logic signed [COEF_W-1:0] coefs [NTAPS];

  assign core_start = core_valid && core_ready;

  if (IN_REG) begin : g_in_reg
    logic                     ir_v;
    logic signed [DATA_W-1:0] ir_q;
    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        ir_v <= 1'b0;
        ir_q <= '0;
      end else if (clk_en) begin
        if (in_valid && in_ready) begin
          ir_v <= 1'b1;
          ir_q <= in_data;
        end else if (core_start) begin
          ir_v <= 1'b0;
        end
      end
    end
    assign in_ready   = !ir_v || core_ready;
    assign core_valid = ir_v;
    assign core_data  = ir_q;
  end else begin : g_in_wire
    assign in_ready   = core_ready;
    assign core_valid = in_valid;
    assign core_data  = in_data;
  end

  sfir_coef_bank #(.NTAPS(NTAPS), .COEF_W(COEF_W), .AW(AW)) u_bank (
    .clk(clk), .rst(rst), .ce(clk_en),
    .wr_en(coef_we), .wr_done(coef_done), .wr_addr(coef_addr), .wr_data(coef_din),
    .sample_start(core_start), .act_coef(coefs)
  );

  sfir_tap_line #(.NTAPS(NTAPS), .DATA_W(DATA_W)) u_taps (
    .clk(clk), .rst(rst), .ce(clk_en), .shift(core_start),
    .din(core_data), .taps(taps)
  );

  sfir_mac #(
    .NTAPS(NTAPS), .PHASES(PHASES), .DATA_W(DATA_W), .COEF_W(COEF_W),
    .FRAC_W(FRAC_W), .NMULT(NMULT)
  ) u_mac (
    .clk(clk), .rst(rst), .ce(clk_en), .start(core_start),
    .taps(taps), .coefs(coefs), .res_pop(res_pop),
    .ready(core_ready), .res_v(res_v), .res_q(res_q)
  );

  if (OUT_REG) begin : g_out_reg
    logic                     or_v;
    logic signed [DATA_W-1:0] or_q;
    assign res_pop = res_v && (!or_v || out_ready);
    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        or_v <= 1'b0;
        or_q <= '0;
      end else if (clk_en) begin
        if (res_pop) begin
          or_v <= 1'b1;
          or_q <= res_q;
        end else if (out_ready) begin
          or_v <= 1'b0;
        end
      end
    end
    assign out_valid = or_v;
    assign out_data  = or_q;
  end else begin : g_out_wire
    assign res_pop   = res_v && out_ready;
    assign out_valid = res_v;
    assign out_data  = res_q;
  end

  // R8: stalled output holds
  a_r8_out_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9: disabled clock enable freezes the output
  a_r9_freeze: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(out_valid) && $stable(out_data)));
endmodule

// File: tb/sfir_prog_tb.sv
`timescale 1ns/1ps
module sfir_prog_tb;
  localparam int NT = 11;

  logic clk = 1'b0, rst = 1'b1, clk_en = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b1, coef_we = 1'b0, coef_done = 1'b0;
  logic signed [15:0] in_data = '0, coef_din = '0;
  logic [3:0] coef_addr = '0;
  logic in_ready, out_valid;
  logic signed [15:0] out_data;

  sfir_prog u_dut (
    .clk(clk), .rst(rst), .clk_en(clk_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .coef_we(coef_we), .coef_done(coef_done), .coef_addr(coef_addr), .coef_din(coef_din)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { longint val; string tag; } exp_t;
  exp_t   sb [$];
  exp_t   popped;
  int     out_times [$];
  int     n_cmp = 0, n_bad = 0, n_out = 0, last_in_cyc = 0;
  longint act_m [NT], shd_m [NT], hist [NT], new_c [NT];
  bit     pend = 0, finished = 0;
  string  tag = "R1";

  task automatic chk(input bit ok, input string rq, input longint a, input longint e);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, a, e);
    end
  endtask

  function automatic longint model();
    longint s = 0;
    for (int k = 0; k < NT; k++) s += act_m[k] * hist[k];
    s = (s + 16384) >>> 15;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic send(input int x);
    if (pend) begin
      for (int k = 0; k < NT; k++) act_m[k] = shd_m[k];
      pend = 0;
    end
    for (int k = NT-1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    sb.push_back('{model(), tag});
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'(x);
    while (!(in_ready && clk_en)) @(negedge clk);
    last_in_cyc = cyc;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic write_one(input int a, input int v);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = 4'(a); coef_din = 16'(v);
    if (a < NT) shd_m[a] = v;
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic write_all();
    for (int i = 0; i < NT; i++) begin
      @(negedge clk);
      coef_we = 1'b1; coef_addr = 4'(i); coef_din = 16'(new_c[i]);
      shd_m[i] = new_c[i];
    end
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic pulse_done();
    coef_done = 1'b1;
    pend = 1;
    @(negedge clk);
    coef_done = 1'b0;
  endtask

  task automatic drain(input string rq);
    int g = 0;
    while (sb.size() != 0 && g < 3000) begin
      @(negedge clk);
      g++;
    end
    chk(sb.size() == 0, rq, sb.size(), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready && clk_en) begin
      out_times.push_back(cyc);
      n_out++;
      if (sb.size() == 0) chk(1'b0, "R2", out_data, 0);
      else begin
        popped = sb.pop_front();
        chk(longint'(out_data) == popped.val, popped.tag, out_data, popped.val);
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic ov;
    logic signed [15:0] od;
    int nsave;
    for (int k = 0; k < NT; k++) begin act_m[k] = 0; shd_m[k] = 0; hist[k] = 0; end

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(in_ready == 1'b1, "R1", in_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", out_valid, 0);

    // R1 zero coefficients, R4 latency
    tag = "R1";
    send(12345);
    while (!out_valid) @(negedge clk);
    chk(cyc - last_in_cyc == 10, "R4", cyc - last_in_cyc, 10);
    send(-2222);
    drain("R1");

    // R2 rounding with one half-weight tap
    for (int k = 0; k < NT; k++) new_c[k] = 0;
    new_c[0] = 16384;
    write_all(); pulse_done();
    tag = "R2";
    send(1); send(-1); send(3); send(-3);
    drain("R2");

    // R2 mixed coefficients, R3 burst throughput
    for (int k = 0; k < NT; k++) new_c[k] = (k % 2 == 1) ? -(k+1)*900 : (k+1)*700;
    write_all(); pulse_done();
    drain("R2");
    out_times.delete();
    for (int i = 0; i < 6; i++) send((i % 2 == 0) ? 12000 - i*1500 : -7000 + i*333);
    drain("R3");
    for (int i = 1; i < out_times.size(); i++)
      chk(out_times[i] - out_times[i-1] == 7, "R3", out_times[i] - out_times[i-1], 7);

    // R6 writes while a sample is in flight
    for (int k = 0; k < NT; k++) new_c[k] = 3000 - k*450;
    tag = "R6";
    send(20000);
    write_all(); pulse_done();
    drain("R6");
    tag = "R7";
    send(-15000); send(9000);
    drain("R7");

    // R7 writes without done have no effect until done
    for (int k = 0; k < NT; k++) new_c[k] = -2500 + k*611;
    write_all();
    tag = "R7";
    send(17000);
    drain("R7");
    @(negedge clk); pulse_done();
    send(-4000); send(8000);
    drain("R7");

    // R5 in-range and out-of-range single writes
    write_one(4, 30000);
    write_one(13, 32767);
    @(negedge clk); pulse_done();
    tag = "R5";
    for (int i = 0; i < 6; i++) send(5000 + i*1234);
    drain("R5");

    // R8 back-pressure
    out_ready = 1'b0;
    tag = "R8";
    for (int i = 0; i < 4; i++) send(-6000 + i*4100);
    repeat (30) @(negedge clk);
    chk(in_ready == 1'b0, "R8", in_ready, 0);
    ov = out_valid; od = out_data;
    chk(ov == 1'b1, "R8", ov, 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(out_valid == ov && out_data == od, "R8", out_data, od);
    end
    out_ready = 1'b1;
    drain("R8");

    // R9 clock enable freeze
    tag = "R9";
    send(25000);
    forever begin
      @(posedge clk);
      #1;
      if (out_valid) break;
    end
    clk_en = 1'b0;
    nsave = n_out; od = out_data;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b1 && out_data == od, "R9", out_data, od);
    end
    chk(n_out == nsave, "R9", n_out, nsave);
    @(negedge clk); clk_en = 1'b1;
    drain("R9");

    // R10 saturation both ways
    for (int k = 0; k < NT; k++) new_c[k] = 32767;
    write_all(); pulse_done();
    tag = "R10";
    for (int i = 0; i < NT; i++) send(32767);
    for (int i = 0; i < NT; i++) send(-32768);
    drain("R10");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule